// File: doc/BRIEF.md
# Parallel polyphase decimating low-pass filter

The block filters two baseband paths, in-phase and quadrature, that arrive as four parallel lanes each per clock from a quarter-rate mixer. Each path is a stream of samples interleaved across the lanes: lane 0 holds the oldest sample of the clock's block and lane 3 the newest. Each output lane computes a full linear convolution over the current block and the blocks of earlier clocks. The whole structure runs at one block per clock with no input buffering.

One prototype low-pass filter with an even number of taps serves both paths. Its odd-addressed coefficients form the in-phase half filter and its even-addressed coefficients form the quadrature half filter. Each half is then shared across the four lane branches, so every branch has the same length. Coefficients are written into a shadow bank and swapped in with a commit pulse. This lets a running receiver switch between a wide and a narrow passband. An optional extra 2x decimation keeps only the even output lanes of each path.

Top module: `ppf_decim_fir`

## Requirements
- R1: After reset `out_valid_o` is 0, both output buses are zero, and the sample history and both coefficient banks are zero.
- R2: In-phase output lane k for a block whose lane 0 is stream sample n equals the sum over j = 0..TAPS/2-1 of cI[j]·xI[n+k-j]. Here cI[j] is the coefficient at address 2j+1, and samples before reset count as 0.
- R3: The quadrature path uses the same convolution with cQ[j], the coefficient at address 2j, applied to its own stream xQ.
- R4: The convolution reaches back across clock boundaries. A lone nonzero sample contributes to later output lanes and later blocks for TAPS/2 sample positions, and to none after that.
- R5: A coefficient write (`coef_we_i`, `coef_addr_i`, `coef_data_i`) updates only the shadow bank. Filtered outputs keep using the previous coefficients until a commit.
- R6: A `coef_commit_i` pulse copies the whole shadow bank into the active bank in one clock. The copy does not include a write issued in that same cycle. Every output computed from a block presented one or more cycles later uses the new taps.
- R7: Latency is exactly two clocks. `out_valid_o` repeats `in_valid_i` two cycles later, back-to-back blocks give back-to-back outputs, and I and Q lanes are always sample-aligned.
- R8: A cycle with `in_valid_i` low neither shifts the sample history nor changes the output buses, and its output slot has `out_valid_o` low.
- R9: The full-precision sum is divided by 2^FRAC_W and rounded to nearest, with exact halves rounded toward +infinity.
- R10: The rounded result is saturated to the signed OUT_W range, from -2^(OUT_W-1) to 2^(OUT_W-1)-1.
- R11: With `dec2_i` = 1 at the output clock, output lane 0 carries filtered lane 0, output lane 1 carries filtered lane 2, lanes 2 and 3 are zero, and `out_valid_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input block valid |
| in_i_i | input | LANES*DATA_W | In-phase lanes, lane k at bits [k*DATA_W +: DATA_W], signed |
| in_q_i | input | LANES*DATA_W | Quadrature lanes, same packing |
| coef_we_i | input | 1 | Shadow coefficient write enable |
| coef_addr_i | input | $clog2(TAPS) | Prototype coefficient address, odd addresses to I and even to Q |
| coef_data_i | input | COEF_W | Signed coefficient, FRAC_W fraction bits |
| coef_commit_i | input | 1 | Copy shadow bank to active bank |
| dec2_i | input | 1 | 1 selects the extra 2x decimation |
| out_valid_o | output | 1 | Output block valid |
| out_i_o | output | LANES*OUT_W | Filtered in-phase lanes, signed |
| out_q_o | output | LANES*OUT_W | Filtered quadrature lanes, signed |

## Verification
The bench drives impulses placed on single lanes, so a branch that takes its history window from the wrong lane offset or from the wrong clock shows up as a misplaced or missing echo. It swaps the two coefficient parities, which would put the wrong taps on I and Q. It loads shadow taps without committing, which catches a bank that leaks writes straight into the filter. Exact half values on either side of zero expose rounding toward zero or away from zero. Full-scale inputs against full-scale taps show whether the output wraps instead of clamping. Gapped input and 2x mode check that idle cycles leave the history and the outputs untouched and that lanes 0 and 2 land in the correct slots.

// File: rtl/ppf_pkg.sv
package ppf_pkg;
  typedef enum logic {
    DEC_1X = 1'b0,
    DEC_2X = 1'b1
  } dec_mode_e;
endpackage

// File: rtl/ppf_coef_bank.sv
module ppf_coef_bank #(
  parameter int TAPS   = 64,
  parameter int COEF_W = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [$clog2(TAPS)-1:0]       addr_i,
  input  logic [COEF_W-1:0]             data_i,
  input  logic                          commit_i,
  output logic [(TAPS/2)*COEF_W-1:0]    act_i_o,
  output logic [(TAPS/2)*COEF_W-1:0]    act_q_o
);
  localparam int HT = TAPS / 2;

  logic [COEF_W-1:0] shd_q  [TAPS];
  logic [COEF_W-1:0] live_q [TAPS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TAPS; i++) begin
        shd_q[i]  <= '0;
        live_q[i] <= '0;
      end
    end else begin
      if (we_i) shd_q[addr_i] <= data_i;
      // commit takes the pre-edge shadow: a same-cycle write lands next commit
      if (commit_i) begin
        for (int i = 0; i < TAPS; i++) live_q[i] <= shd_q[i];
      end
    end
  end

  for (genvar j = 0; j < HT; j++) begin : g_split
    assign act_i_o[j*COEF_W +: COEF_W] = live_q[2*j+1];
    assign act_q_o[j*COEF_W +: COEF_W] = live_q[2*j];
  end
endmodule

// File: rtl/ppf_hist.sv
module ppf_hist #(
  parameter int LANES  = 4,
  parameter int HT     = 32,
  parameter int DATA_W = 12
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                valid_i,
  input  logic [LANES*DATA_W-1:0]             lanes_i,
  output logic [(HT+LANES-1)*DATA_W-1:0]      win_o
);
  localparam int W = HT + LANES - 1;

  // index 0 is the newest sample
  logic [DATA_W-1:0] h_q [W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < W; i++) h_q[i] <= '0;
    end else if (valid_i) begin
      for (int i = 0; i < LANES; i++) h_q[i] <= lanes_i[(LANES-1-i)*DATA_W +: DATA_W];
      for (int i = LANES; i < W; i++) h_q[i] <= h_q[i-LANES];
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_win
    assign win_o[i*DATA_W +: DATA_W] = h_q[i];
  end
endmodule

// File: rtl/ppf_branch.sv
module ppf_branch #(
  parameter int HT     = 32,
  parameter int DATA_W = 12,
  parameter int COEF_W = 16,
  parameter int OUT_W  = 16,
  parameter int FRAC_W = 15
) (
  input  logic [HT*DATA_W-1:0] smp_i,
  input  logic [HT*COEF_W-1:0] coef_i,
  output logic [OUT_W-1:0]     y_o
);
  localparam int PW    = DATA_W + COEF_W;
  localparam int ACC_W = PW + $clog2(HT);
  localparam logic signed [ACC_W:0] HALF =
    {{(ACC_W-FRAC_W+1){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic signed [ACC_W:0] MAXV = {{(ACC_W-OUT_W+2){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W:0] MINV = {{(ACC_W-OUT_W+2){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [PW-1:0]    prod [HT];
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W:0]   rnd;
  logic signed [ACC_W:0]   shr;

  for (genvar j = 0; j < HT; j++) begin : g_mul
    assign prod[j] = signed'(smp_i[j*DATA_W +: DATA_W]) * signed'(coef_i[j*COEF_W +: COEF_W]);
  end

  always_comb begin
    acc = '0;
    for (int j = 0; j < HT; j++) acc = acc + ACC_W'(prod[j]);
    rnd = {acc[ACC_W-1], acc} + HALF;
    shr = rnd >>> FRAC_W;
    if (shr > MAXV)      y_o = MAXV[OUT_W-1:0];
    else if (shr < MINV) y_o = MINV[OUT_W-1:0];
    else                 y_o = shr[OUT_W-1:0];
  end
endmodule

// File: rtl/ppf_decim_fir.sv
module ppf_decim_fir #(
  parameter int LANES  = 4,
  parameter int TAPS   = 64,
  parameter int DATA_W = 12,
  parameter int COEF_W = 16,
  parameter int OUT_W  = 16,
  parameter int FRAC_W = 15
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      in_valid_i,
  input  logic [LANES*DATA_W-1:0]   in_i_i,
  input  logic [LANES*DATA_W-1:0]   in_q_i,
  input  logic                      coef_we_i,
  input  logic [$clog2(TAPS)-1:0]   coef_addr_i,
  input  logic [COEF_W-1:0]         coef_data_i,
  input  logic                      coef_commit_i,
  input  logic                      dec2_i,
  output logic                      out_valid_o,
  output logic [LANES*OUT_W-1:0]    out_i_o,
  output logic [LANES*OUT_W-1:0]    out_q_o
);
  import ppf_pkg::*;

  localparam int HT = TAPS / 2;
  localparam int W  = HT + LANES - 1;

  logic [HT*COEF_W-1:0]  act_i_w, act_q_w;
  logic [W*DATA_W-1:0]   win_i_w, win_q_w;
  logic [OUT_W-1:0]      yi_w [LANES];
  logic [OUT_W-1:0]      yq_w [LANES];
  logic [LANES*OUT_W-1:0] sel_i_w, sel_q_w;
  logic [LANES*OUT_W-1:0] out_i_q, out_q_q;
  logic                  hv_q, ov_q;
  dec_mode_e             mode;

  assign mode = dec_mode_e'(dec2_i);

  ppf_coef_bank #(.TAPS(TAPS), .COEF_W(COEF_W)) i_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (coef_we_i),
    .addr_i   (coef_addr_i),
    .data_i   (coef_data_i),
    .commit_i (coef_commit_i),
    .act_i_o  (act_i_w),
    .act_q_o  (act_q_w)
  );

  ppf_hist #(.LANES(LANES), .HT(HT), .DATA_W(DATA_W)) i_hist_i (
    .clk_i (clk_i), .rst_ni (rst_ni), .valid_i (in_valid_i),
    .lanes_i (in_i_i), .win_o (win_i_w)
  );

  ppf_hist #(.LANES(LANES), .HT(HT), .DATA_W(DATA_W)) i_hist_q (
    .clk_i (clk_i), .rst_ni (rst_ni), .valid_i (in_valid_i),
    .lanes_i (in_q_i), .win_o (win_q_w)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    // lane k window starts LANES-1-k positions behind the newest sample
    ppf_branch #(.HT(HT), .DATA_W(DATA_W), .COEF_W(COEF_W), .OUT_W(OUT_W), .FRAC_W(FRAC_W))
      i_br_i (
        .smp_i  (win_i_w[(LANES-1-k)*DATA_W +: HT*DATA_W]),
        .coef_i (act_i_w),
        .y_o    (yi_w[k])
      );
    ppf_branch #(.HT(HT), .DATA_W(DATA_W), .COEF_W(COEF_W), .OUT_W(OUT_W), .FRAC_W(FRAC_W))
      i_br_q (
        .smp_i  (win_q_w[(LANES-1-k)*DATA_W +: HT*DATA_W]),
        .coef_i (act_q_w),
        .y_o    (yq_w[k])
      );
    if (k < LANES/2) begin : g_lo
      assign sel_i_w[k*OUT_W +: OUT_W] = (mode == DEC_2X) ? yi_w[2*k] : yi_w[k];
      assign sel_q_w[k*OUT_W +: OUT_W] = (mode == DEC_2X) ? yq_w[2*k] : yq_w[k];
    end else begin : g_hi
      assign sel_i_w[k*OUT_W +: OUT_W] = (mode == DEC_2X) ? '0 : yi_w[k];
      assign sel_q_w[k*OUT_W +: OUT_W] = (mode == DEC_2X) ? '0 : yq_w[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hv_q    <= 1'b0;
      ov_q    <= 1'b0;
      out_i_q <= '0;
      out_q_q <= '0;
    end else begin
      hv_q <= in_valid_i;
      ov_q <= hv_q;
      if (hv_q) begin
        out_i_q <= sel_i_w;
        out_q_q <= sel_q_w;
      end
    end
  end

  assign out_valid_o = ov_q;
  assign out_i_o     = out_i_q;
  assign out_q_o     = out_q_q;
endmodule

// File: rtl/ppf_decim_fir_chk.sv
module ppf_decim_fir_chk #(
  parameter int LANES  = 4,
  parameter int OUT_W  = 16,
  parameter int HT     = 32,
  parameter int COEF_W = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     in_valid_i,
  input logic                     coef_commit_i,
  input logic                     dec2_i,
  input logic                     out_valid_o,
  input logic [LANES*OUT_W-1:0]   out_i_o,
  input logic [LANES*OUT_W-1:0]   out_q_o,
  input logic [HT*COEF_W-1:0]     act_i,
  input logic [HT*COEF_W-1:0]     act_q
);
  localparam int HB = (LANES/2)*OUT_W;

  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              age_q <= '0;
    else if (age_q != 2'd3)   age_q <= age_q + 2'd1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2) |-> (out_valid_o == $past(in_valid_i, 2))); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd1 && !out_valid_o) |-> ($stable(out_i_o) && $stable(out_q_o))); // R8

  AST_COEF_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd1 && !$past(coef_commit_i)) |-> ($stable(act_i) && $stable(act_q))); // R5

  AST_DEC2_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd1 && out_valid_o && $past(dec2_i)) |->
      (out_i_o[LANES*OUT_W-1:HB] == '0 && out_q_o[LANES*OUT_W-1:HB] == '0)); // R11
endmodule

bind ppf_decim_fir ppf_decim_fir_chk #(
  .LANES(LANES), .OUT_W(OUT_W), .HT(TAPS/2), .COEF_W(COEF_W)
) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .in_valid_i    (in_valid_i),
  .coef_commit_i (coef_commit_i),
  .dec2_i        (dec2_i),
  .out_valid_o   (out_valid_o),
  .out_i_o       (out_i_o),
  .out_q_o       (out_q_o),
  .act_i         (act_i_w),
  .act_q         (act_q_w)
);

// File: tb/test_ppf_decim_fir.sv
module test_ppf_decim_fir;
  localparam int LANES  = 4;
  localparam int TAPS   = 64;
  localparam int DATA_W = 12;
  localparam int COEF_W = 16;
  localparam int OUT_W  = 16;
  localparam int FRAC_W = 15;
  localparam int HT     = TAPS / 2;
  localparam int AW     = $clog2(TAPS);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid = 1'b0;
  logic [LANES*DATA_W-1:0] in_i = '0, in_q = '0;
  logic coef_we = 1'b0, coef_commit = 1'b0, dec2 = 1'b0;
  logic [AW-1:0] coef_addr = '0;
  logic [COEF_W-1:0] coef_data = '0;
  logic out_valid;
  logic [LANES*OUT_W-1:0] out_i, out_q;

  always #10 clk = ~clk;

  ppf_decim_fir #(.LANES(LANES), .TAPS(TAPS), .DATA_W(DATA_W), .COEF_W(COEF_W),
                  .OUT_W(OUT_W), .FRAC_W(FRAC_W)) i_ppf_decim_fir (
    .clk_i (clk), .rst_ni (rst_ni), .in_valid_i (in_valid), .in_i_i (in_i), .in_q_i (in_q),
    .coef_we_i (coef_we), .coef_addr_i (coef_addr), .coef_data_i (coef_data),
    .coef_commit_i (coef_commit), .dec2_i (dec2),
    .out_valid_o (out_valid), .out_i_o (out_i), .out_q_o (out_q)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int shd [TAPS];
  int act [TAPS];
  int xi [0:2047];
  int xq [0:2047];
  int ns = 0;
  int cyc = 0;
  int bi [LANES];
  int bq [LANES];
  int e_i [4][LANES];
  int e_q [4][LANES];
  bit e_v [4];
  string e_r [4];
  int last_i [LANES];
  int last_q [LANES];
  int unsigned seed = 32'h1234_5678;

  function automatic int smp(bit isq, int idx);
    if (idx < 0) return 0;
    return isq ? xq[idx] : xi[idx];
  endfunction

  function automatic int rsat(longint a);
    longint r, mx, mn;
    mx = (longint'(1) <<< (OUT_W-1)) - 1;
    mn = -(longint'(1) <<< (OUT_W-1));
    r = (a + (longint'(1) <<< (FRAC_W-1))) >>> FRAC_W;
    if (r > mx) return int'(mx);
    if (r < mn) return int'(mn);
    return int'(r);
  endfunction

  function automatic int filt(bit isq, int idx);
    longint acc = 0;
    for (int j = 0; j < HT; j++)
      acc += longint'(isq ? act[2*j] : act[2*j+1]) * longint'(smp(isq, idx - j));
    return rsat(acc);
  endfunction

  function automatic int lcg();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) & 32'hFFF) - 2048;
  endfunction

  task automatic check(string req, string what, int act_v, int exp_v);
    n_chk++;
    if (act_v != exp_v) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
    end
  endtask

  // one clock: check output due from two cycles back, then drive this cycle
  task automatic tick(bit v, string req);
    int s, a;
    int ri [LANES];
    int rq [LANES];
    s = (cyc + 2) % 4;
    check(e_r[s], "out_valid", int'(out_valid), int'(e_v[s]));
    for (int k = 0; k < LANES; k++) begin
      a = int'($signed(out_i[k*OUT_W +: OUT_W]));
      if (e_v[s]) last_i[k] = e_i[s][k];
      check(e_r[s], $sformatf("I lane %0d", k), a, last_i[k]);
      a = int'($signed(out_q[k*OUT_W +: OUT_W]));
      if (e_v[s]) last_q[k] = e_q[s][k];
      check(e_r[s], $sformatf("Q lane %0d", k), a, last_q[k]);
    end
    s = cyc % 4;
    e_v[s] = v;
    e_r[s] = req;
    if (v) begin
      for (int k = 0; k < LANES; k++) begin
        xi[ns+k] = bi[k];
        xq[ns+k] = bq[k];
      end
      for (int k = 0; k < LANES; k++) begin
        ri[k] = filt(1'b0, ns + k);
        rq[k] = filt(1'b1, ns + k);
      end
      for (int k = 0; k < LANES; k++) begin
        if (!dec2) begin
          e_i[s][k] = ri[k]; e_q[s][k] = rq[k];
        end else if (k < LANES/2) begin
          e_i[s][k] = ri[2*k]; e_q[s][k] = rq[2*k];
        end else begin
          e_i[s][k] = 0; e_q[s][k] = 0;
        end
      end
      ns += LANES;
    end
    in_valid = v;
    for (int k = 0; k < LANES; k++) begin
      in_i[k*DATA_W +: DATA_W] = bi[k][DATA_W-1:0];
      in_q[k*DATA_W +: DATA_W] = bq[k][DATA_W-1:0];
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(1'b0, "R8");
  endtask

  task automatic wcoef(int addr, int val);
    coef_we = 1'b1;
    coef_addr = AW'(addr);
    coef_data = COEF_W'(val);
    shd[addr] = val;
    tick(1'b0, "R8");
    coef_we = 1'b0;
  endtask

  task automatic commit();
    coef_commit = 1'b1;
    for (int i = 0; i < TAPS; i++) act[i] = shd[i];
    tick(1'b0, "R8");
    coef_commit = 1'b0;
  endtask

  task automatic set_block(int a0, int a1, int a2, int a3, int q0, int q1, int q2, int q3);
    bi[0] = a0; bi[1] = a1; bi[2] = a2; bi[3] = a3;
    bq[0] = q0; bq[1] = q1; bq[2] = q2; bq[3] = q3;
  endtask

  task automatic t_reset();
    check("R1", "out_valid after reset", int'(out_valid), 0);
    check("R1", "out_i after reset", (out_i == '0) ? 0 : 1, 0);
    check("R1", "out_q after reset", (out_q == '0) ? 0 : 1, 0);
    set_block(700, -300, 500, 100, -800, 20, 40, -60);
    tick(1'b1, "R1 zero taps");
    set_block(0, 0, 0, 0, 0, 0, 0, 0);
    idle(3);
  endtask

  task automatic load_ramp();
    for (int a = 0; a < TAPS; a++)
      wcoef(a, (a % 2) ? (a + 1) * 150 : -(a + 3) * 97);
    commit();
    idle(2);
  endtask

  task automatic t_impulse();
    set_block(0, 0, 1024, 0, 0, -512, 0, 0);
    tick(1'b1, "R2 R3 R4 impulse");
    set_block(0, 0, 0, 0, 0, 0, 0, 0);
    for (int b = 0; b < 10; b++) tick(1'b1, "R4 echo");
    idle(2);
  endtask

  task automatic t_stream();
    for (int b = 0; b < 24; b++) begin
      for (int k = 0; k < LANES; k++) begin bi[k] = lcg(); bq[k] = lcg(); end
      tick(1'b1, "R2 R3 R7 stream");
    end
    idle(2);
  endtask

  task automatic t_gaps();
    for (int b = 0; b < 12; b++) begin
      for (int k = 0; k < LANES; k++) begin bi[k] = lcg(); bq[k] = lcg(); end
      tick(1'b1, "R8 gapped");
      for (int k = 0; k < LANES; k++) begin bi[k] = lcg(); bq[k] = lcg(); end
      tick(1'b0, "R8 idle garbage");
      if (b % 3 == 0) tick(1'b0, "R8 idle garbage");
    end
    idle(2);
  endtask

  task automatic t_shadow();
    for (int a = 0; a < TAPS; a++) wcoef(a, (a % 2) ? -(a * 211) : (a * 173) - 4000);
    for (int b = 0; b < 10; b++) begin
      for (int k = 0; k < LANES; k++) begin bi[k] = lcg(); bq[k] = lcg(); end
      tick(1'b1, "R5 old taps");
    end
    idle(2);
    commit();
    for (int b = 0; b < 10; b++) begin
      for (int k = 0; k < LANES; k++) begin bi[k] = lcg(); bq[k] = lcg(); end
      tick(1'b1, "R6 new taps");
    end
    idle(2);
  endtask

  task automatic t_round();
    for (int a = 0; a < TAPS; a++) wcoef(a, 0);
    wcoef(1, 16384);
    wcoef(0, 16383);
    commit();
    idle(2);
    set_block(1, -1, 3, -3, 1, 2, -1, -2);
    tick(1'b1, "R9 halves");
    set_block(5, -5, 2, 0, 3, -3, 0, 1);
    tick(1'b1, "R9 halves");
    idle(2);
    // hand values for x*0.5: 1->1, -1->0, 3->2, -3->-1
    check("R9", "tie +0.5", int'($signed(out_i[0 +: OUT_W])), 3);
  endtask

  task automatic t_sat();
    for (int a = 0; a < TAPS; a++) wcoef(a, (a % 2) ? 32767 : -32768);
    commit();
    idle(2);
    for (int b = 0; b < 10; b++) begin
      set_block(2047, 2047, 2047, 2047, -2048, 2047, -2048, 2047);
      tick(1'b1, "R10 clamp");
    end
    for (int b = 0; b < 10; b++) begin
      set_block(-2048, -2048, -2048, -2048, 2047, 2047, 2047, 2047);
      tick(1'b1, "R10 clamp");
    end
    idle(2);
    check("R10", "neg clamp I", int'($signed(out_i[0 +: OUT_W])), -32768);
    check("R10", "neg clamp Q", int'($signed(out_q[0 +: OUT_W])), -32768);
  endtask

  task automatic t_dec2();
    load_ramp();
    dec2 = 1'b1;
    for (int b = 0; b < 16; b++) begin
      for (int k = 0; k < LANES; k++) begin bi[k] = lcg(); bq[k] = lcg(); end
      tick(1'b1, "R11 dec2");
    end
    idle(2);
    dec2 = 1'b0;
    idle(1);
  endtask

  initial begin
    for (int i = 0; i < TAPS; i++) begin shd[i] = 0; act[i] = 0; end
    for (int i = 0; i < 4; i++) begin
      e_v[i] = 1'b0; e_r[i] = "R1";
      for (int k = 0; k < LANES; k++) begin e_i[i][k] = 0; e_q[i][k] = 0; end
    end
    for (int k = 0; k < LANES; k++) begin last_i[k] = 0; last_q[k] = 0; bi[k] = 0; bq[k] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    load_ramp();
    t_impulse();
    t_stream();
    t_gaps();
    t_shadow();
    t_round();
    t_sat();
    t_dec2();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule